// File: doc/BRIEF.md
# Programmable-Length Serial Shift Register

A one-bit serial delay line whose length runs from 1 to 64 stages. Six binary-weighted length controls each add their weight to the length, and a single fixed stage is always present, so the length is one plus the weighted sum. The storage is a fixed head stage followed by segments of 32, 16, 8, 4, 2 and 1 stages. Each control either puts its segment into the data path or routes around it. A source select picks which of two serial inputs feeds the head stage. Tying one input back to the output makes the register recirculate its contents.

Two asynchronous trigger lines are brought into the system clock domain. A shift takes place when the positive trigger rises while the negative trigger is low. A shift also takes place when the negative trigger falls while the positive trigger is high. No other trigger transition causes a shift. An active-low asynchronous reset clears every stage. The block drives the serial output and its complement.

Top module: `varlen_shreg`

## Requirements
- R1: The length L equals 1 plus the sum of 2^n over every bit n of `len_sel_i` that is set. With the length held constant since reset, after k shifts `q_o` equals the bit shifted in on shift k-L+1 when k >= L, and 0 when k < L.
- R2: On a shift, the head stage takes `din_a_i` when `src_sel_i` is 0 and `din_b_i` when `src_sel_i` is 1.
- R3: A rise of `trig_pos_i` while `trig_neg_i` is low causes exactly one shift. Its result shows on `q_o` at the third rising clock edge after the input change.
- R4: A fall of `trig_neg_i` while `trig_pos_i` is high causes exactly one shift, with the same latency as R3.
- R5: No other trigger transition shifts the register. This covers a fall of `trig_pos_i`, a rise of `trig_neg_i`, a rise of `trig_pos_i` while `trig_neg_i` is high, and a fall of `trig_neg_i` while `trig_pos_i` is low.
- R6: The internal shift enable never lasts more than one clock cycle.
- R7: While `rst_ni` is low, every stage is cleared at once, without waiting for a clock edge. `q_o` is 0 and `qn_o` is 1, and trigger activity has no effect.
- R8: `qn_o` is always the inverse of `q_o`.
- R9: `len_sel_i` is captured only on a shift. A change to it with no shift leaves `q_o` unchanged and clears no stored data.
- R10: After the length changes without a reset, once 64 shifts have occurred at the new length, `q_o` follows the R1 delay for the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all stages |
| trig_pos_i | input | 1 | Asynchronous trigger; shifts on its rise while trig_neg_i is low |
| trig_neg_i | input | 1 | Asynchronous trigger; shifts on its fall while trig_pos_i is high |
| src_sel_i | input | 1 | Serial source select: 0 selects din_a_i, 1 selects din_b_i |
| din_a_i | input | 1 | Serial data input A |
| din_b_i | input | 1 | Serial data input B |
| len_sel_i | input | NUM_SEG | Weighted length controls; bit n adds 2^n stages |
| q_o | output | 1 | Serial output at the end of the selected path |
| qn_o | output | 1 | Complement of q_o |

## Verification
Every length from 1 to 64 is swept after a fresh reset, each with L+4 shifts of pseudo-random data on both inputs and a pseudo-random source select. This separates the zero-filled start-up shifts from the delayed data. Odd lengths use negative-trigger shifts and even lengths use positive-trigger shifts, so both trigger modes are tried across every segment combination. Targeted patterns cover three further cases:
- non-qualifying trigger transitions at length 1, with data opposite to the current output, so any spurious shift would flip `q_o`;
- a length change with no shift, then a full flush at the new length;
- a reset asserted between clock edges in mid-sequence, with a trigger pulse applied while reset is held.

// File: rtl/vls_pkg.sv
package vls_pkg;
  // segment idx (0 = nearest head) holds 2^(n_seg-1-idx) stages
  function automatic int unsigned seg_len(int unsigned n_seg, int unsigned idx);
    return 32'd1 << (n_seg - 1 - idx);
  endfunction
endpackage

// File: rtl/vls_trig.sv
module vls_trig #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  output logic shift_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] pos_sync, neg_sync;
  logic pos_prev, neg_prev;
  logic pos_now, neg_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_sync <= '0;
      neg_sync <= '0;
      pos_prev <= 1'b0;
      neg_prev <= 1'b0;
    end else begin
      pos_sync[0] <= pos_i;
      neg_sync[0] <= neg_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        pos_sync[i] <= pos_sync[i-1];
        neg_sync[i] <= neg_sync[i-1];
      end
      pos_prev <= pos_sync[LAST];
      neg_prev <= neg_sync[LAST];
    end
  end

  assign pos_now = pos_sync[LAST];
  assign neg_now = neg_sync[LAST];
  // rise of pos with neg low, or fall of neg with pos high
  assign shift_o = (pos_now & ~pos_prev & ~neg_now) |
                   (~neg_now & neg_prev & pos_now);

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |=> !shift_o);

  assert_no_fall_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pos_now) && !$fell(neg_now)) |-> !shift_o);
endmodule

// File: rtl/vls_seg.sv
module vls_seg #(
  parameter int unsigned LEN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic d_i,
  output logic tap_o
);
  logic [LEN-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (shift_i) begin
      st_q[0] <= d_i;
      for (int i = 1; i < LEN; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign tap_o = st_q[LEN-1];

  assert_seg_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> st_q[0] == $past(d_i));

  assert_seg_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(tap_o));
endmodule

// File: rtl/varlen_shreg.sv
module varlen_shreg
  import vls_pkg::*;
#(
  parameter int unsigned NUM_SEG     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_pos_i,
  input  logic               trig_neg_i,
  input  logic               src_sel_i,
  input  logic               din_a_i,
  input  logic               din_b_i,
  input  logic [NUM_SEG-1:0] len_sel_i,
  output logic               q_o,
  output logic               qn_o
);
  logic               shift_en;
  logic [NUM_SEG-1:0] len_q;
  logic               din_sel;
  logic               head_q;
  logic [NUM_SEG:0]   chain;
  logic [NUM_SEG-1:0] tap;

  vls_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pos_i  (trig_pos_i),
    .neg_i  (trig_neg_i),
    .shift_o(shift_en)
  );

  assign din_sel = src_sel_i ? din_b_i : din_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      head_q <= 1'b0;
    end else if (shift_en) begin
      len_q  <= len_sel_i;
      head_q <= din_sel;
    end
  end

  assign chain[0] = head_q;

  // largest segment sits next to the head stage
  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    localparam int unsigned W = NUM_SEG - 1 - j;
    vls_seg #(.LEN(seg_len(NUM_SEG, j))) u_seg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(shift_en),
      .d_i    (chain[j]),
      .tap_o  (tap[j])
    );
    assign chain[j+1] = len_q[W] ? tap[j] : chain[j];
  end

  assign q_o  = chain[NUM_SEG];
  assign qn_o = ~q_o;

  assert_hold_between_shifts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en |=> $stable(q_o));

  assert_len_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> len_q == $past(len_sel_i));

  assert_head_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en && src_sel_i) |=> head_q == $past(din_b_i));

  assert_head_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en |=> $stable(head_q));
endmodule

// File: tb/varlen_shreg_tb.sv
module varlen_shreg_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       trig_pos_i = 1'b0;
  logic       trig_neg_i = 1'b0;
  logic       src_sel_i = 1'b0;
  logic       din_a_i = 1'b0;
  logic       din_b_i = 1'b0;
  logic [5:0] len_sel_i = '0;
  logic       q_o, qn_o;

  varlen_shreg dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_pos_i(trig_pos_i), .trig_neg_i(trig_neg_i),
    .src_sel_i(src_sel_i), .din_a_i(din_a_i), .din_b_i(din_b_i),
    .len_sel_i(len_sel_i), .q_o(q_o), .qn_o(qn_o)
  );

  always #10 clk_i = ~clk_i;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    nsh     = 0;
  int    cur_len = 1;
  bit    hist [0:4095];
  logic [15:0] lf = 16'hACE1;

  task automatic check(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (len %0d, shifts %0d)", tag, act, exp, cur_len, nsh);
    end
  endtask

  function automatic logic model_q();
    if (nsh >= cur_len) return hist[nsh - cur_len];
    return 1'b0;
  endfunction

  task automatic chk_q(input string tag);
    check(q_o, model_q(), tag);
    check(qn_o, ~q_o, "R8");
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic next_rand();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic set_data(input bit a, input bit b, input bit s);
    din_a_i = a; din_b_i = b; src_sel_i = s;
  endtask

  task automatic record();
    hist[nsh] = src_sel_i ? din_b_i : din_a_i;
    nsh++;
  endtask

  // R3 mode: neg low, pos pulse
  task automatic shift_pos();
    trig_pos_i = 1'b1; wait_n(4);
    trig_pos_i = 1'b0; wait_n(4);
    record();
  endtask

  // R4 mode: pos held high, neg pulsed low
  task automatic enter_neg_mode();
    trig_neg_i = 1'b1; wait_n(4);
    trig_pos_i = 1'b1; wait_n(4);
  endtask
  task automatic shift_neg();
    trig_neg_i = 1'b0; wait_n(4);
    trig_neg_i = 1'b1; wait_n(4);
    record();
  endtask
  task automatic exit_neg_mode();
    trig_pos_i = 1'b0; wait_n(4);
    trig_neg_i = 1'b0; wait_n(4);
  endtask

  task automatic do_reset();
    trig_pos_i = 1'b0; trig_neg_i = 1'b0;
    rst_ni = 1'b0; wait_n(2);
    rst_ni = 1'b1; wait_n(1);
    nsh = 0;
  endtask

  bit done = 1'b0;

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic q_keep;
    wait_n(2);
    #3;
    check(q_o, 1'b0, "R7 reset q");
    check(qn_o, 1'b1, "R7 reset qn");
    do_reset();
    check(q_o, 1'b0, "R7 after release");

    // full length sweep, both trigger modes
    for (int len = 1; len <= 64; len++) begin
      do_reset();
      cur_len = len;
      len_sel_i = 6'(len - 1);
      if (len % 2 == 1) enter_neg_mode();
      for (int k = 0; k < len + 4; k++) begin
        next_rand();
        set_data(lf[0], lf[5], lf[9]);
        if (len % 2 == 1) begin
          shift_neg();
          chk_q("R1 R4 R2");
        end else begin
          shift_pos();
          chk_q("R1 R3 R2");
        end
      end
      if (len % 2 == 1) exit_neg_mode();
    end

    // R2 explicit source select at length 1
    do_reset();
    cur_len = 1; len_sel_i = 6'd0;
    set_data(1'b1, 1'b0, 1'b0); shift_pos(); check(q_o, 1'b1, "R2 select A");
    set_data(1'b1, 1'b0, 1'b1); shift_pos(); check(q_o, 1'b0, "R2 select B");
    set_data(1'b0, 1'b1, 1'b1); shift_pos(); check(q_o, 1'b1, "R2 select B");

    // R5 non-qualifying transitions, data opposite to q
    q_keep = q_o;
    set_data(~q_keep, ~q_keep, 1'b0);
    trig_neg_i = 1'b1; wait_n(4);   // neg rise
    check(q_o, q_keep, "R5 neg rise");
    trig_pos_i = 1'b1; wait_n(4);   // pos rise with neg high
    check(q_o, q_keep, "R5 pos rise neg high");
    trig_pos_i = 1'b0; wait_n(4);   // pos fall
    check(q_o, q_keep, "R5 pos fall");
    trig_neg_i = 1'b0; wait_n(4);   // neg fall with pos low
    check(q_o, q_keep, "R5 neg fall pos low");
    shift_pos();
    check(q_o, ~q_keep, "R3 shift after R5");

    // R9 / R10 length change without reset
    do_reset();
    cur_len = 5; len_sel_i = 6'd4;
    for (int k = 0; k < 12; k++) begin
      next_rand(); set_data(lf[2], lf[7], lf[11]); shift_pos();
    end
    chk_q("R1 pre-change");
    q_keep = q_o;
    len_sel_i = 6'd39;
    wait_n(10);
    check(q_o, q_keep, "R9 no shift no change");
    cur_len = 40;
    for (int k = 0; k < 70; k++) begin
      next_rand(); set_data(lf[1], lf[6], lf[3]); shift_pos();
      if (k >= 64) chk_q("R10 new length");
    end

    // R7 mid-sequence reset
    do_reset();
    cur_len = 8; len_sel_i = 6'd7;
    for (int k = 0; k < 12; k++) begin
      set_data(1'b1, 1'b1, k[0]); shift_pos();
    end
    check(q_o, 1'b1, "R1 ones before reset");
    #3 rst_ni = 1'b0;
    #1;
    check(q_o, 1'b0, "R7 async clear q");
    check(qn_o, 1'b1, "R7 async clear qn");
    trig_pos_i = 1'b1; wait_n(4); trig_pos_i = 1'b0; wait_n(4);
    check(q_o, 1'b0, "R7 trigger ignored in reset");
    rst_ni = 1'b1; wait_n(1);
    nsh = 0;
    for (int k = 0; k < 10; k++) begin
      next_rand(); set_data(lf[4], lf[8], lf[12]); shift_pos();
      chk_q("R7 R1 after reset");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule